// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps the delivery state for a bank of interrupt sources and turns their events into delivery offers for a presentation controller. Each source holds a target server number, a priority and a small status word. A strap input marks each source as either a level-sensitive line or a message-signalled trigger. A priority of 0xFF masks a source. An offer carries the target server, the global source number (local index plus a base offset) and the priority.

The presentation side reports back with reject and end-of-interrupt notices, which carry global numbers. It can also request a resend. A resend walks all sources in index order, one source per cycle, and re-offers what is eligible. Message sources that were refused are replayed. Level sources whose line is still high and that are not already in flight are delivered again. Offers leave through a registered valid/ready handshake. When several sources become eligible together, they queue and are handed out lowest index first.

Top module: `isc_top`

## Requirements
- R1: After reset no offer is valid, every source is masked (priority 0xFF) with clear status and server 0, and a message trigger arriving while masked produces no offer.
- R2: A message trigger on an unmasked source produces one offer carrying that source's server, its global number and its priority.
- R3: A message trigger on a masked source is remembered. A later configuration write that gives it a priority other than 0xFF releases exactly one offer. A second such write releases nothing more.
- R4: A level source sets its asserted state to follow its line. A rising line on an unmasked source that is not in flight produces one offer and marks the source in flight. While the source is in flight, further rising edges produce no offer. After an end-of-interrupt notice, the next rising edge delivers again.
- R5: A configuration write to a level source whose line is high and which is not in flight produces an offer with the newly written server and priority, provided the new priority is not 0xFF.
- R6: A reject notice marks a message source as refused. The next resend clears the mark and re-offers the source once if its priority is not 0xFF. If the priority is 0xFF, the resend clears the mark and offers nothing. A later resend offers nothing.
- R7: A reject notice on a level source clears its in-flight state, so a resend re-offers it while its line is still high. An end-of-interrupt notice on a message source has no effect.
- R8: Reject and end-of-interrupt notices whose global number lies outside BASE to BASE+N-1 change no source.
- R9: While an offer is valid and not accepted, its server, number and priority hold still. Offers that become eligible together are delivered one after another in ascending index order.
- R10: The resend scan does not advance while an offer is outstanding. Offers it produces therefore leave in ascending index order, each waiting for the previous one to be accepted.
- R11: The global number equals BASE plus the local index. BASE defaults to 0x1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_is_lvl | input | N | Per-source type strap: 1 = level line, 0 = message trigger |
| src_in | input | N | Per-source input: the line for level sources, a one-cycle trigger for message sources |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local index of the source being configured |
| cfg_srv | input | SRV_W | Target server to store |
| cfg_prio | input | 8 | Priority to store (0xFF masks) |
| rej_vld | input | 1 | Reject notice strobe |
| rej_num | input | NUM_W | Global number of the rejected source |
| eoi_vld | input | 1 | End-of-interrupt notice strobe |
| eoi_num | input | NUM_W | Global number of the finished source |
| resend_req | input | 1 | Starts a resend scan when none is running |
| ofr_vld | output | 1 | Offer valid |
| ofr_rdy | input | 1 | Offer accepted by the presentation side |
| ofr_srv | output | SRV_W | Offer target server |
| ofr_num | output | NUM_W | Offer global source number |
| ofr_prio | output | 8 | Offer priority |

## Verification
The bench aims at the memory in the status word. If a design dropped the masked-pending mark, unmasking would stay silent. If it forgot to clear that mark, a second unmask would produce a duplicate offer. If it mishandled the in-flight state of level sources, held or re-pulsed lines would flood the output, or a rejected line would never come back on resend. Out-of-window notices use numbers that alias onto live sources when the offset is truncated, so a design without the window test would wrongly replay a source. Simultaneous triggers and a stalled resend, with ready held low, expose offers that change while waiting, or that are lost or reordered.

// File: rtl/isc_pkg.sv
// Package: shared types and constants for the interrupt source controller.
// Assumes an 8-bit priority where the all-ones value means masked.
package isc_pkg;
    localparam int PRIO_W = 8;
    localparam logic [PRIO_W-1:0] PRIO_OFF = 8'hFF;

    // Per-source status flags
    typedef struct packed {
        logic asserted;   // level line currently high
        logic sent;       // level source in flight
        logic rejected;   // message source refused, waiting for resend
        logic mpend;      // message source triggered while masked
    } src_stat_t;
endpackage

// File: rtl/isc_slot.sv
// Module: state of one interrupt source. It applies triggers, line changes,
// configuration, reject, end-of-interrupt and scan visits in one cycle, and
// raises a delivery request. Assumes at most one scan visit per cycle and
// that `taken` is asserted only while the request is raised.
module isc_slot
    import isc_pkg::*;
#(
    parameter int SRV_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_lvl,
    input  logic              src_in,
    input  logic              cfg_hit,
    input  logic [SRV_W-1:0]  cfg_srv,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic              rej_hit,
    input  logic              eoi_hit,
    input  logic              scan_hit,
    input  logic              taken,
    output logic              want,
    output logic [SRV_W-1:0]  srv,
    output logic [PRIO_W-1:0] prio
);
    src_stat_t         st_q, st_d;
    logic [SRV_W-1:0]  srv_q, srv_d;
    logic [PRIO_W-1:0] prio_q, prio_d;
    logic              want_q, want_d;
    logic              chk;

    // Next-state: apply every event of this cycle in a fixed order
    always_comb begin
        st_d   = st_q;
        srv_d  = srv_q;
        prio_d = prio_q;
        want_d = want_q & ~taken;
        chk    = 1'b0;
        if (is_lvl) begin
            st_d.asserted = src_in;
            if (src_in && !st_q.asserted) chk = 1'b1;
        end else if (src_in) begin
            if (prio_q == PRIO_OFF) st_d.mpend = 1'b1;
            else                    want_d = 1'b1;
        end
        if (rej_hit) begin
            if (is_lvl) st_d.sent = 1'b0;
            else        st_d.rejected = 1'b1;
        end
        if (eoi_hit && is_lvl) st_d.sent = 1'b0;
        if (cfg_hit) begin
            srv_d  = cfg_srv;
            prio_d = cfg_prio;
            if (is_lvl) begin
                chk = 1'b1;
            end else if (st_d.mpend && cfg_prio != PRIO_OFF) begin
                st_d.mpend = 1'b0;
                want_d     = 1'b1;
            end
        end
        if (scan_hit) begin
            if (is_lvl) begin
                chk = 1'b1;
            end else if (st_d.rejected) begin
                st_d.rejected = 1'b0;
                if (prio_d != PRIO_OFF) want_d = 1'b1;
            end
        end
        if (chk && prio_d != PRIO_OFF && st_d.asserted && !st_d.sent) begin
            st_d.sent = 1'b1;
            want_d    = 1'b1;
        end
    end

    // State registers with synchronous reset to the masked state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= '0;
            srv_q  <= '0;
            prio_q <= PRIO_OFF;
            want_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            srv_q  <= srv_d;
            prio_q <= prio_d;
            want_q <= want_d;
        end
    end

    assign want = want_q;
    assign srv  = srv_q;
    assign prio = prio_q;

    assert_sent_needs_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.sent) |-> (is_lvl && st_q.asserted && prio_q != PRIO_OFF));
    assert_reject_msg_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rejected |-> !is_lvl);
    assert_mpend_msg_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mpend |-> !is_lvl);
endmodule

// File: rtl/isc_offer.sv
// Module: picks the lowest-index requesting source and holds its offer in a
// register until the consumer accepts it. Assumes source requests stay
// raised until taken.
module isc_offer
    import isc_pkg::*;
#(
    parameter int N     = 8,
    parameter int SRV_W = 4,
    parameter int IDX_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N-1:0]               want,
    input  logic [N-1:0][SRV_W-1:0]    srv_arr,
    input  logic [N-1:0][PRIO_W-1:0]   prio_arr,
    input  logic                       rdy,
    output logic [N-1:0]               taken,
    output logic                       vld,
    output logic [IDX_W-1:0]           idx,
    output logic [SRV_W-1:0]           srv,
    output logic [PRIO_W-1:0]          prio
);
    logic [IDX_W-1:0] pick;
    logic             any;
    logic             load;

    // Lowest-index priority pick
    always_comb begin
        pick = '0;
        any  = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (want[i]) begin
                pick = IDX_W'(i);
                any  = 1'b1;
            end
        end
    end

    assign load  = any && (!vld || rdy);
    assign taken = load ? (N'(1) << pick) : '0;

    // Offer holding register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld  <= 1'b0;
            idx  <= '0;
            srv  <= '0;
            prio <= PRIO_OFF;
        end else if (load) begin
            vld  <= 1'b1;
            idx  <= pick;
            srv  <= srv_arr[pick];
            prio <= prio_arr[pick];
        end else if (rdy) begin
            vld  <= 1'b0;
        end
    end

    assert_hold_offer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !rdy) |=> (vld && $stable(idx) && $stable(srv) && $stable(prio)));
    assert_one_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(taken));
endmodule

// File: rtl/isc_scan.sv
// Module: resend walker. It visits source 0 to N-1, one per cycle, and
// pauses while an offer is outstanding. Requests that arrive during a walk
// are dropped.
module isc_scan #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req,
    input  logic         stall,
    output logic [N-1:0] hit
);
    logic             busy;
    logic [IDX_W-1:0] pos;
    logic             step;

    assign step = busy && !stall;
    assign hit  = step ? (N'(1) << pos) : '0;

    // Walk position and busy flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            pos  <= '0;
        end else if (step) begin
            if (pos == IDX_W'(N - 1)) begin
                busy <= 1'b0;
                pos  <= '0;
            end else begin
                pos  <= pos + 1'b1;
            end
        end else if (!busy && req) begin
            busy <= 1'b1;
            pos  <= '0;
        end
    end

    assert_scan_stalls_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stall) |=> (busy && $stable(pos)));
endmodule

// File: rtl/isc_top.sv
// Module: interrupt source controller top. It decodes global numbers into
// local source strobes, instantiates one slot per source, the resend walker
// and the offer register. Assumes BASE+N fits in NUM_W bits.
module isc_top
    import isc_pkg::*;
#(
    parameter int N     = 8,
    parameter int SRV_W = 4,
    parameter int NUM_W = 16,
    parameter int BASE  = 'h1000,
    localparam int IDX_W = (N < 2) ? 1 : $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      src_is_lvl,
    input  logic [N-1:0]      src_in,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [SRV_W-1:0]  cfg_srv,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic              rej_vld,
    input  logic [NUM_W-1:0]  rej_num,
    input  logic              eoi_vld,
    input  logic [NUM_W-1:0]  eoi_num,
    input  logic              resend_req,
    output logic              ofr_vld,
    input  logic              ofr_rdy,
    output logic [SRV_W-1:0]  ofr_srv,
    output logic [NUM_W-1:0]  ofr_num,
    output logic [PRIO_W-1:0] ofr_prio
);
    localparam logic [NUM_W-1:0] LO = NUM_W'(BASE);
    localparam logic [NUM_W-1:0] HI = NUM_W'(BASE + N);

    logic [N-1:0]              cfg_hit, rej_hit, eoi_hit, scan_hit, want, taken;
    logic [N-1:0][SRV_W-1:0]   srv_arr;
    logic [N-1:0][PRIO_W-1:0]  prio_arr;
    logic [NUM_W-1:0]          rej_off, eoi_off;
    logic [IDX_W-1:0]          ofr_idx;

    // Window decode of notices into one-hot local strobes
    always_comb begin
        rej_off = rej_num - LO;
        eoi_off = eoi_num - LO;
        rej_hit = (rej_vld && rej_num >= LO && rej_num < HI) ? (N'(1) << rej_off[IDX_W-1:0]) : '0;
        eoi_hit = (eoi_vld && eoi_num >= LO && eoi_num < HI) ? (N'(1) << eoi_off[IDX_W-1:0]) : '0;
        cfg_hit = cfg_we ? (N'(1) << cfg_idx) : '0;
    end

    for (genvar g = 0; g < N; g++) begin : g_src
        isc_slot #(.SRV_W(SRV_W)) i_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .is_lvl   (src_is_lvl[g]),
            .src_in   (src_in[g]),
            .cfg_hit  (cfg_hit[g]),
            .cfg_srv  (cfg_srv),
            .cfg_prio (cfg_prio),
            .rej_hit  (rej_hit[g]),
            .eoi_hit  (eoi_hit[g]),
            .scan_hit (scan_hit[g]),
            .taken    (taken[g]),
            .want     (want[g]),
            .srv      (srv_arr[g]),
            .prio     (prio_arr[g])
        );
    end

    isc_scan #(.N(N), .IDX_W(IDX_W)) i_scan (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (resend_req),
        .stall (ofr_vld),
        .hit   (scan_hit)
    );

    isc_offer #(.N(N), .SRV_W(SRV_W), .IDX_W(IDX_W)) i_offer (
        .clk      (clk),
        .rst_n    (rst_n),
        .want     (want),
        .srv_arr  (srv_arr),
        .prio_arr (prio_arr),
        .rdy      (ofr_rdy),
        .taken    (taken),
        .vld      (ofr_vld),
        .idx      (ofr_idx),
        .srv      (ofr_srv),
        .prio     (ofr_prio)
    );

    assign ofr_num = LO + NUM_W'(ofr_idx);

    assert_num_in_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ofr_vld |-> (ofr_num >= LO && ofr_num < HI));
endmodule

// File: tb/test_isc_top.sv
// Directed bench for isc_top: one task per scenario, each checking itself.
module test_isc_top;
    localparam int N = 8;
    localparam int SRV_W = 4;
    localparam int NUM_W = 16;
    localparam int IDX_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] src_is_lvl = 8'hF0;   // 0..3 message, 4..7 level
    logic [N-1:0] src_in = '0;
    logic cfg_we = 1'b0;
    logic [IDX_W-1:0] cfg_idx = '0;
    logic [SRV_W-1:0] cfg_srv = '0;
    logic [7:0] cfg_prio = '0;
    logic rej_vld = 1'b0, eoi_vld = 1'b0, resend_req = 1'b0, ofr_rdy = 1'b0;
    logic [NUM_W-1:0] rej_num = '0, eoi_num = '0;
    logic ofr_vld;
    logic [SRV_W-1:0] ofr_srv;
    logic [NUM_W-1:0] ofr_num;
    logic [7:0] ofr_prio;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    isc_top i_isc_top (
        .clk(clk), .rst_n(rst_n), .src_is_lvl(src_is_lvl), .src_in(src_in),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_srv(cfg_srv), .cfg_prio(cfg_prio),
        .rej_vld(rej_vld), .rej_num(rej_num), .eoi_vld(eoi_vld), .eoi_num(eoi_num),
        .resend_req(resend_req), .ofr_vld(ofr_vld), .ofr_rdy(ofr_rdy),
        .ofr_srv(ofr_srv), .ofr_num(ofr_num), .ofr_prio(ofr_prio)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg(input int idx, input int srv, input int prio);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_srv = SRV_W'(srv); cfg_prio = 8'(prio);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input logic [N-1:0] m);
        @(negedge clk);
        src_in = src_in | m;
        @(negedge clk);
        src_in = src_in & ~m;
    endtask

    task automatic line(input int idx, input bit v);
        @(negedge clk);
        src_in[idx] = v;
        @(negedge clk);
    endtask

    task automatic reject(input int num);
        @(negedge clk);
        rej_vld = 1'b1; rej_num = NUM_W'(num);
        @(negedge clk);
        rej_vld = 1'b0;
    endtask

    task automatic eoi(input int num);
        @(negedge clk);
        eoi_vld = 1'b1; eoi_num = NUM_W'(num);
        @(negedge clk);
        eoi_vld = 1'b0;
    endtask

    task automatic resend();
        @(negedge clk);
        resend_req = 1'b1;
        @(negedge clk);
        resend_req = 1'b0;
    endtask

    // Wait for an offer, compare it, then accept it
    task automatic take(input int srv, input int num, input int prio, input string tag);
        int w = 0;
        while (!ofr_vld && w < 30) begin
            @(negedge clk);
            w++;
        end
        check(ofr_vld, {tag, " offer missing"}, 32'(ofr_vld), 32'd1);
        if (ofr_vld)
            check(ofr_srv == SRV_W'(srv) && ofr_num == NUM_W'(num) && ofr_prio == 8'(prio),
                  {tag, " offer fields"}, {4'(ofr_srv), 8'(ofr_prio), ofr_num},
                  {4'(srv), 8'(prio), 16'(num)});
        ofr_rdy = 1'b1;
        @(negedge clk);
        ofr_rdy = 1'b0;
    endtask

    task automatic quiet(input int cycles, input string tag);
        bit seen = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (ofr_vld) seen = 1'b1;
        end
        check(!seen, {tag, " unexpected offer"}, {ofr_num, 8'(ofr_prio)}, 32'd0);
        if (seen) begin
            ofr_rdy = 1'b1;
            @(negedge clk);
            ofr_rdy = 1'b0;
        end
    endtask

    task automatic t_reset();
        check(!ofr_vld, "R1 valid after reset", 32'(ofr_vld), 32'd0);
        pulse(8'h08);                      // source 3 masked: remembered
        quiet(10, "R1 masked trigger");
    endtask

    task automatic t_msg();
        cfg(0, 3, 5);
        quiet(5, "R2 config without trigger");
        pulse(8'h01);
        take(3, 'h1000, 5, "R2 source 0");
        cfg(2, 7, 'h10);
        pulse(8'h04);
        take(7, 'h1002, 'h10, "R11 source 2 number");
    endtask

    task automatic t_mpend();
        cfg(3, 1, 8);
        take(1, 'h1003, 8, "R3 unmask releases");
        cfg(3, 1, 8);
        quiet(8, "R3 second unmask");
        cfg(1, 2, 'hFF);
        pulse(8'h02);
        quiet(6, "R3 masked source 1");
        cfg(1, 2, 4);
        take(2, 'h1001, 4, "R3 source 1 released");
    endtask

    task automatic t_level();
        cfg(4, 5, 6);
        quiet(5, "R4 config with line low");
        line(4, 1'b1);
        take(5, 'h1004, 6, "R4 rising line");
        quiet(6, "R4 line held");
        line(4, 1'b0);
        line(4, 1'b1);
        quiet(6, "R4 re-pulse while in flight");
        eoi('h1004);
        quiet(6, "R4 eoi alone");
        line(4, 1'b0);
        line(4, 1'b1);
        take(5, 'h1004, 6, "R4 rising after eoi");
    endtask

    task automatic t_cfg_level();
        line(5, 1'b1);
        quiet(6, "R5 masked line");
        cfg(5, 9, 3);
        take(9, 'h1005, 3, "R5 config delivers");
    endtask

    task automatic t_lvl_reject();
        reject('h1005);
        quiet(5, "R7 reject alone");
        resend();
        take(9, 'h1005, 3, "R7 level resend");
        eoi('h1000);
        resend();
        quiet(N + 8, "R7 eoi on message");
    endtask

    task automatic t_msg_reject();
        pulse(8'h01);
        take(3, 'h1000, 5, "R6 source 0 again");
        reject('h1000);
        quiet(5, "R6 reject alone");
        resend();
        take(3, 'h1000, 5, "R6 replay");
        resend();
        quiet(N + 8, "R6 second resend");
        reject('h1002);
        cfg(2, 7, 'hFF);
        resend();
        quiet(N + 8, "R6 masked replay");
        cfg(2, 7, 'h10);
        quiet(6, "R6 mark cleared");
    endtask

    task automatic t_window();
        reject('h1008);
        reject('h0FFF);
        eoi('h100C);
        resend();
        quiet(N + 8, "R8 out of window");
    endtask

    task automatic t_order();
        pulse(8'h05);
        while (!ofr_vld) @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            check(ofr_vld && ofr_num == 16'h1000 && ofr_srv == 4'd3 && ofr_prio == 8'd5,
                  "R9 stalled offer stable", {ofr_num, 8'(ofr_prio)}, {16'h1000, 8'd5});
            @(negedge clk);
        end
        take(3, 'h1000, 5, "R9 first");
        take(7, 'h1002, 'h10, "R9 second");
    endtask

    task automatic t_scan_stall();
        reject('h1000);
        reject('h1002);
        resend();
        while (!ofr_vld) @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            check(ofr_num == 16'h1000, "R10 scan paused", ofr_num, 32'h1000);
            @(negedge clk);
        end
        take(3, 'h1000, 5, "R10 scan first");
        take(7, 'h1002, 'h10, "R10 scan second");
        quiet(N + 6, "R10 scan done");
    endtask

    initial begin : watchdog
        wait (cyc > 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_msg();
        t_mpend();
        t_level();
        t_cfg_level();
        t_lvl_reject();
        t_msg_reject();
        t_window();
        t_order();
        t_scan_stall();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule